// File: doc/BRIEF.md
# Multi-Channel Copy Engine Register Decoder

This block is the register front end of a copy engine with several independent channels. A host reaches it through a simple single-beat request port. Each access moves 1, 2, 4 or 8 bytes. The low 128 bytes of the address space hold a few global registers. Above that, every channel has its own 128-byte window. In that window sit its control word, a status view, a 64-bit descriptor-chain pointer, a 64-bit completion-record pointer, a command byte and an error word.

Some reads have side effects. A read of the attention word clears it. A read of the interrupt control word clears the master enable. A read of a channel's control word marks the channel as in use. The two 64-bit pointers can be written whole, or one 32-bit half at a time. Error bits are cleared by writing ones to them. A command write does not stay in the register. It leaves the block as a one-cycle pulse aimed at the addressed channel's engine, carrying the command byte. The engines report back through per-channel busy, status and error-set inputs, plus a shared attention-set input.

Top module: `xfer_csr_hub`

## Requirements
- R1: Every request with `req_valid` high gets a response: `rsp_valid` is high in the following cycle, for that one cycle only. `rsp_valid` is low after a cycle with no request, and it is low out of reset.
- R2: Global offset 0x00, read with size code 0 (1 byte), returns the channel count `NCH`. Global offset 0x01, size code 0, returns the bit index of the highest set bit of `XFER_CAP`. Size codes are 0=1, 1=2, 2=4 and 3=8 bytes.
- R3: The attention word is at global offset 0x02... see R4; the attention word itself is at global offset 0x04 (size code 2). It ORs in `attn_set` every cycle. A read returns the current value and then clears it, but bits set in the same cycle as the read are kept.
- R4: Interrupt control is at global offset 0x02 (size code 0). Bit 0 is the master enable and is written from `req_wdata[0]`. A read returns the value and then clears bit 0.
- R5: Writes to the channel count, the transfer-capability exponent, the attention word and a channel's status are ignored and get a normal, error-free response.
- R6: Channel i owns the window at byte address 0x80*(i+1). A window index at or above `NCH` is an error (see R12).
- R7: The chain pointer (low at window offset 0x10, high at 0x14) and the completion pointer (low at 0x18, high at 0x1C) behave the same way. A 4-byte write to the low register replaces bits 31:0. A 4-byte write to the high register replaces bits 63:32. An 8-byte write to the low register replaces all 64 bits. A 4-byte read of the low register returns bits 31:0, and a 4-byte read of the high register returns bits 63:32. An 8-byte read of the low register returns all 64 bits.
- R8: The error word is at window offset 0x20 (size code 2). A write clears every bit that is 1 in `req_wdata[31:0]`. Bits from `chan_err_set` are ORed in every cycle and win over a clear in the same cycle.
- R9: The control word is at window offset 0x00 (size code 1) and is 16 bits wide. A read returns its value and then sets bit 0, the in-use flag.
- R10: The command byte is at window offset 0x04 (size code 0). A write raises `cmd_pulse[i]` for one cycle, in the response cycle, with `cmd_byte` equal to `req_wdata[7:0]`. At most one pulse bit is high at a time. A read of the command byte returns 0.
- R11: Status is at window offset 0x08 (size code 3). A read returns `chan_status` for that channel, zero-extended, with bit 0 forced to 1 while the channel's busy input is low.
- R12: An unmapped offset, an out-of-range channel, or a size code other than the one(s) listed for the register gives `rsp_err`=1 with `rsp_rdata`=0. Such an access changes no register and raises no command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset into the register space |
| req_size | input | 2 | Access size code (0=1, 1=2, 2=4, 3=8 bytes) |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | 64 | Read data, right-aligned, 0 on writes and errors |
| attn_set | input | 32 | Attention bits to set |
| chan_busy | input | NCH | Per-channel engine busy |
| chan_status | input | NCH*STAT_W | Per-channel engine status |
| chan_err_set | input | NCH*32 | Per-channel error bits to set |
| cmd_pulse | output | NCH | One-cycle command strobe per channel |
| cmd_byte | output | 8 | Command value accompanying the strobe |

## Verification
The bound checker watches the handshake timing on every cycle. It checks that responses follow requests one to one, that an errored response carries no data, and that command strobes are one-hot and come only from successful writes. The register semantics can only be shown by the bench's scenarios. These are the clear-on-read and set-on-read effects, the half-word pointer merges, write-1-to-clear racing against engine sets, and an illegal access leaving the registers unchanged. Each of these needs a sequence of accesses whose later reads reveal the earlier state.

// File: rtl/xcsr_pkg.sv
package xcsr_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_CNT, RS_CAP, RS_INTR, RS_ATTN,
    RS_CTRL, RS_CMD, RS_STAT, RS_CHLO, RS_CHHI, RS_CPLO, RS_CPHI, RS_ERR
  } rsel_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SZ_D = 2'd3;

  // global window offsets
  localparam logic [6:0] G_CNT  = 7'h00;
  localparam logic [6:0] G_CAP  = 7'h01;
  localparam logic [6:0] G_INTR = 7'h02;
  localparam logic [6:0] G_ATTN = 7'h04;

  // per-channel window offsets
  localparam logic [6:0] C_CTRL = 7'h00;
  localparam logic [6:0] C_CMD  = 7'h04;
  localparam logic [6:0] C_STAT = 7'h08;
  localparam logic [6:0] C_CHLO = 7'h10;
  localparam logic [6:0] C_CHHI = 7'h14;
  localparam logic [6:0] C_CPLO = 7'h18;
  localparam logic [6:0] C_CPHI = 7'h1C;
  localparam logic [6:0] C_ERR  = 7'h20;

  function automatic int msb_index(input longint unsigned v);
    int r;
    r = 0;
    for (int b = 0; b < 64; b++) begin
      if (v[b]) r = b;
    end
    return r;
  endfunction

  // merge a write into a 64-bit pointer held as two halves
  function automatic logic [63:0] ptr_merge(input logic [63:0] old,
                                            input logic [63:0] wd,
                                            input logic        hi,
                                            input logic        full);
    logic [63:0] r;
    r = old;
    if (full)    r = wd;
    else if (hi) r[63:32] = wd[31:0];
    else         r[31:0]  = wd[31:0];
    return r;
  endfunction

endpackage

// File: rtl/xcsr_decode.sv
module xcsr_decode
  import xcsr_pkg::*;
#(
  parameter int AW  = 12,
  parameter int NCH = 4,
  localparam int CIW = AW - 7
)(
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     size,
  output rsel_e          sel,
  output logic [CIW-1:0] chan,
  output logic           is_glob,
  output logic           hit
);

  logic [CIW-1:0] win;
  logic [6:0]     off;
  logic           size_ok;
  logic           chan_ok;

  assign win     = addr[AW-1:7];
  assign off     = addr[6:0];
  assign is_glob = (win == '0);
  assign chan    = win - 1'b1;
  assign chan_ok = is_glob || (int'(win) <= NCH);

  always_comb begin
    sel     = RS_NONE;
    size_ok = 1'b0;
    if (is_glob) begin
      case (off)
        G_CNT:   begin sel = RS_CNT;  size_ok = (size == SZ_B); end
        G_CAP:   begin sel = RS_CAP;  size_ok = (size == SZ_B); end
        G_INTR:  begin sel = RS_INTR; size_ok = (size == SZ_B); end
        G_ATTN:  begin sel = RS_ATTN; size_ok = (size == SZ_W); end
        default: ;
      endcase
    end else begin
      case (off)
        C_CTRL:  begin sel = RS_CTRL; size_ok = (size == SZ_H); end
        C_CMD:   begin sel = RS_CMD;  size_ok = (size == SZ_B); end
        C_STAT:  begin sel = RS_STAT; size_ok = (size == SZ_D); end
        C_CHLO:  begin sel = RS_CHLO; size_ok = (size == SZ_W) || (size == SZ_D); end
        C_CHHI:  begin sel = RS_CHHI; size_ok = (size == SZ_W); end
        C_CPLO:  begin sel = RS_CPLO; size_ok = (size == SZ_W) || (size == SZ_D); end
        C_CPHI:  begin sel = RS_CPHI; size_ok = (size == SZ_W); end
        C_ERR:   begin sel = RS_ERR;  size_ok = (size == SZ_W); end
        default: ;
      endcase
    end
  end

  assign hit = (sel != RS_NONE) && size_ok && chan_ok;

endmodule

// File: rtl/xcsr_glob.sv
module xcsr_glob
  import xcsr_pkg::*;
#(
  parameter int              NCH      = 4,
  parameter longint unsigned XFER_CAP = 4096
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc,
  input  logic        wr,
  input  rsel_e       sel,
  input  logic        wbit,
  input  logic [31:0] attn_set,
  output logic [63:0] rdata
);

  localparam logic [7:0] CNT_VAL = 8'(NCH);
  localparam logic [7:0] CAP_VAL = 8'(msb_index(XFER_CAP));

  logic        intr_en;
  logic [31:0] attn;

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_en <= 1'b0;
      attn    <= '0;
    end else begin
      if (acc && sel == RS_INTR) intr_en <= wr ? wbit : 1'b0;
      attn <= ((acc && !wr && sel == RS_ATTN) ? 32'h0 : attn) | attn_set;
    end
  end

  always_comb begin
    case (sel)
      RS_CNT:  rdata = {56'h0, CNT_VAL};
      RS_CAP:  rdata = {56'h0, CAP_VAL};
      RS_INTR: rdata = {63'h0, intr_en};
      RS_ATTN: rdata = {32'h0, attn};
      default: rdata = 64'h0;
    endcase
  end

endmodule

// File: rtl/xcsr_chan.sv
module xcsr_chan
  import xcsr_pkg::*;
#(
  parameter int STAT_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              wr,
  input  rsel_e             sel,
  input  logic [1:0]        size,
  input  logic [63:0]       wdata,
  input  logic [31:0]       err_set,
  input  logic              busy,
  input  logic [STAT_W-1:0] status_in,
  output logic [63:0]       rdata,
  output logic              cmd_fire
);

  logic [15:0] ctrl;
  logic [63:0] chain_ptr;
  logic [63:0] cmpl_ptr;
  logic [31:0] err;
  logic        wr_acc;
  logic        rd_acc;
  logic        full;
  logic [63:0] stat_view;

  assign wr_acc = acc && wr;
  assign rd_acc = acc && !wr;
  assign full   = (size == SZ_D);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      chain_ptr <= '0;
      cmpl_ptr  <= '0;
      err       <= '0;
      cmd_fire  <= 1'b0;
    end else begin
      cmd_fire <= wr_acc && (sel == RS_CMD);
      if (wr_acc && sel == RS_CTRL)      ctrl    <= wdata[15:0];
      else if (rd_acc && sel == RS_CTRL) ctrl[0] <= 1'b1;
      if (wr_acc && (sel == RS_CHLO || sel == RS_CHHI))
        chain_ptr <= ptr_merge(chain_ptr, wdata, sel == RS_CHHI, full);
      if (wr_acc && (sel == RS_CPLO || sel == RS_CPHI))
        cmpl_ptr <= ptr_merge(cmpl_ptr, wdata, sel == RS_CPHI, full);
      err <= (err & ~((wr_acc && sel == RS_ERR) ? wdata[31:0] : 32'h0)) | err_set;
    end
  end

  always_comb begin
    stat_view    = 64'(status_in);
    stat_view[0] = stat_view[0] | ~busy;
  end

  always_comb begin
    case (sel)
      RS_CTRL: rdata = {48'h0, ctrl};
      RS_STAT: rdata = stat_view;
      RS_CHLO: rdata = full ? chain_ptr : {32'h0, chain_ptr[31:0]};
      RS_CHHI: rdata = {32'h0, chain_ptr[63:32]};
      RS_CPLO: rdata = full ? cmpl_ptr : {32'h0, cmpl_ptr[31:0]};
      RS_CPHI: rdata = {32'h0, cmpl_ptr[63:32]};
      RS_ERR:  rdata = {32'h0, err};
      default: rdata = 64'h0;
    endcase
  end

endmodule

// File: rtl/xfer_csr_hub.sv
module xfer_csr_hub
  import xcsr_pkg::*;
#(
  parameter int              NCH      = 4,
  parameter int              AW       = 12,
  parameter longint unsigned XFER_CAP = 4096,
  parameter int              STAT_W   = 16
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [1:0]            req_size,
  input  logic [63:0]           req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [63:0]           rsp_rdata,
  input  logic [31:0]           attn_set,
  input  logic [NCH-1:0]        chan_busy,
  input  logic [NCH*STAT_W-1:0] chan_status,
  input  logic [NCH*32-1:0]     chan_err_set,
  output logic [NCH-1:0]        cmd_pulse,
  output logic [7:0]            cmd_byte
);

  localparam int CIW = AW - 7;

  if (NCH < 1 || NCH > 64 || (NCH + 1) > (1 << CIW)) begin : g_bad_cfg
    initial $error("xfer_csr_hub: NCH out of range for AW");
  end

  rsel_e          sel;
  logic [CIW-1:0] chan;
  logic           is_glob;
  logic           hit;
  logic           ok;
  logic           glob_acc;
  logic [63:0]    glob_rd;
  logic [NCH-1:0] chan_acc;
  logic [63:0]    chan_rd [NCH];
  logic [63:0]    rd_mux;

  xcsr_decode #(.AW(AW), .NCH(NCH)) u_dec (
    .addr(req_addr), .size(req_size), .sel(sel),
    .chan(chan), .is_glob(is_glob), .hit(hit)
  );

  assign ok       = req_valid && hit;
  assign glob_acc = ok && is_glob;

  xcsr_glob #(.NCH(NCH), .XFER_CAP(XFER_CAP)) u_glob (
    .clk(clk), .rst(rst), .acc(glob_acc), .wr(req_write), .sel(sel),
    .wbit(req_wdata[0]), .attn_set(attn_set), .rdata(glob_rd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign chan_acc[i] = ok && !is_glob && (chan == CIW'(i));
    xcsr_chan #(.STAT_W(STAT_W)) u_ch (
      .clk(clk), .rst(rst), .acc(chan_acc[i]), .wr(req_write), .sel(sel),
      .size(req_size), .wdata(req_wdata), .err_set(chan_err_set[i*32 +: 32]),
      .busy(chan_busy[i]), .status_in(chan_status[i*STAT_W +: STAT_W]),
      .rdata(chan_rd[i]), .cmd_fire(cmd_pulse[i])
    );
  end

  always_comb begin
    rd_mux = glob_acc ? glob_rd : 64'h0;
    for (int i = 0; i < NCH; i++) begin
      if (chan_acc[i]) rd_mux = rd_mux | chan_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      cmd_byte  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !hit;
      rsp_rdata <= (ok && !req_write) ? rd_mux : 64'h0;
      cmd_byte  <= (ok && req_write && !is_glob && sel == RS_CMD) ? req_wdata[7:0] : 8'h0;
    end
  end

endmodule

// File: rtl/xcsr_chk.sv
module xcsr_chk #(
  parameter int NCH = 4
)(
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_write,
  input logic           rsp_valid,
  input logic           rsp_err,
  input logic [63:0]    rsp_rdata,
  input logic [NCH-1:0] cmd_pulse,
  input logic [7:0]     cmd_byte
);

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_err_no_data_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == 64'h0));

  assert_cmd_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_pulse));

  assert_cmd_from_write_R10: assert property (@(posedge clk) disable iff (rst)
    (|cmd_pulse) |-> (rsp_valid && !rsp_err && $past(req_write)));

  assert_cmd_byte_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse == '0) |-> (cmd_byte == 8'h0));

endmodule

bind xfer_csr_hub xcsr_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .cmd_pulse(cmd_pulse), .cmd_byte(cmd_byte)
);

// File: tb/sim_xfer_csr_hub.sv
`timescale 1ns/1ps
module sim_xfer_csr_hub;

  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int SW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [63:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_err;
  logic [63:0]       rsp_rdata;
  logic [31:0]       attn_set = '0;
  logic [NCH-1:0]    chan_busy = '0;
  logic [NCH*SW-1:0] chan_status = '0;
  logic [NCH*32-1:0] chan_err_set = '0;
  logic [NCH-1:0]    cmd_pulse;
  logic [7:0]        cmd_byte;

  always #2 clk = ~clk;

  xfer_csr_hub #(.NCH(NCH), .AW(AW), .XFER_CAP(4096), .STAT_W(SW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .attn_set(attn_set), .chan_busy(chan_busy), .chan_status(chan_status),
    .chan_err_set(chan_err_set), .cmd_pulse(cmd_pulse), .cmd_byte(cmd_byte)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [63:0] q_data [$];
  logic        q_err  [$];
  string       q_tag  [$];

  logic [31:0]       pend_attn = '0;
  logic [NCH*32-1:0] pend_err  = '0;

  task automatic check(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R1 unexpected response", 64'(rsp_valid), 64'h0);
      end else begin
        logic [63:0] ed;
        logic        ee;
        string       tg;
        ed = q_data.pop_front();
        ee = q_err.pop_front();
        tg = q_tag.pop_front();
        check(rsp_err === ee, {tg, " err"}, 64'(rsp_err), 64'(ee));
        check(rsp_rdata === ed, {tg, " data"}, rsp_rdata, ed);
      end
    end
  end

  task automatic acc(input bit w, input logic [AW-1:0] a, input logic [1:0] s,
                     input logic [63:0] wd, input logic [63:0] ed, input bit ee,
                     input logic [NCH-1:0] ec, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = wd;
    attn_set = pend_attn; chan_err_set = pend_err;
    q_data.push_back(ed); q_err.push_back(ee); q_tag.push_back(tag);
    @(posedge clk);
    #1;
    req_valid = 1'b0; attn_set = '0; chan_err_set = '0;
    pend_attn = '0; pend_err = '0;
    check(cmd_pulse === ec && (ec == '0 || cmd_byte === wd[7:0]),
          {tag, " cmd"}, {48'h0, cmd_byte, 4'h0, cmd_pulse}, {48'h0, wd[7:0], 4'h0, ec});
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] s, input logic [63:0] ed, input string tag);
    acc(1'b0, a, s, 64'h0, ed, 1'b0, '0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] s, input logic [63:0] wd, input string tag);
    acc(1'b1, a, s, wd, 64'h0, 1'b0, '0, tag);
  endtask

  task automatic bad(input bit w, input logic [AW-1:0] a, input logic [1:0] s, input logic [63:0] wd, input string tag);
    acc(w, a, s, wd, 64'h0, 1'b1, '0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b0 && cmd_pulse === '0, "R1 reset state",
          {59'h0, rsp_valid, cmd_pulse}, 64'h0);

    // R2 identification
    rd(12'h000, 2'd0, 64'd4,  "R2 channel count");
    rd(12'h001, 2'd0, 64'd12, "R2 transfer cap exponent");

    // R5 read-only globals
    wr(12'h000, 2'd0, 64'h9, "R5 write count");
    rd(12'h000, 2'd0, 64'd4, "R5 count unchanged");
    wr(12'h001, 2'd0, 64'h3, "R5 write cap");
    rd(12'h001, 2'd0, 64'd12, "R5 cap unchanged");

    // R3 attention clear-on-read
    @(negedge clk) attn_set = 32'hA5;
    @(negedge clk) attn_set = 32'h0;
    rd(12'h004, 2'd2, 64'hA5, "R3 attention read");
    rd(12'h004, 2'd2, 64'h0,  "R3 attention cleared");
    pend_attn = 32'h100;
    rd(12'h004, 2'd2, 64'h0,  "R3 read with same-cycle set");
    rd(12'h004, 2'd2, 64'h100, "R3 same-cycle set kept");
    @(negedge clk) attn_set = 32'h7;
    @(negedge clk) attn_set = 32'h0;
    wr(12'h004, 2'd2, 64'hFFFF_FFFF, "R5 attention write");
    rd(12'h004, 2'd2, 64'h7, "R5 attention unchanged by write");

    // R4 interrupt control
    wr(12'h002, 2'd0, 64'h1, "R4 enable write");
    rd(12'h002, 2'd0, 64'h1, "R4 enable read");
    rd(12'h002, 2'd0, 64'h0, "R4 enable cleared by read");

    // R9 control set-on-read, channel 0
    wr(12'h080, 2'd1, 64'h1230, "R9 control write");
    rd(12'h080, 2'd1, 64'h1230, "R9 control read");
    rd(12'h080, 2'd1, 64'h1231, "R9 in-use set after read");

    // R7 chain pointer merges, channel 1 (R6 window)
    wr(12'h110, 2'd3, 64'h1111_2222_3333_4444, "R7 chain full write");
    wr(12'h110, 2'd2, 64'hAAAA_BBBB, "R7 chain low write");
    rd(12'h110, 2'd3, 64'h1111_2222_AAAA_BBBB, "R7 low keeps high");
    wr(12'h114, 2'd2, 64'hCCCC_DDDD, "R7 chain high write");
    rd(12'h110, 2'd3, 64'hCCCC_DDDD_AAAA_BBBB, "R7 high keeps low");
    rd(12'h114, 2'd2, 64'hCCCC_DDDD, "R7 high half read");
    rd(12'h110, 2'd2, 64'hAAAA_BBBB, "R7 low half read");
    rd(12'h090, 2'd3, 64'h0, "R6 channel 0 chain untouched");

    // R7 completion pointer, channel 2
    wr(12'h19C, 2'd2, 64'h0000_00FE, "R7 completion high");
    wr(12'h198, 2'd2, 64'h0000_1000, "R7 completion low");
    rd(12'h198, 2'd3, 64'h0000_00FE_0000_1000, "R7 completion merged");

    // R8 error write-1-to-clear, channel 0
    pend_err = '0; pend_err[31:0] = 32'hF0F0;
    rd(12'h0A0, 2'd2, 64'h0, "R8 error before set");
    rd(12'h0A0, 2'd2, 64'hF0F0, "R8 error set");
    wr(12'h0A0, 2'd2, 64'h30, "R8 clear two bits");
    rd(12'h0A0, 2'd2, 64'hF0C0, "R8 after w1c");
    pend_err = '0; pend_err[31:0] = 32'h1;
    wr(12'h0A0, 2'd2, 64'hFFFF_FFFF, "R8 clear all with same-cycle set");
    rd(12'h0A0, 2'd2, 64'h1, "R8 set wins");

    // R10 command strobe, channel 2
    acc(1'b1, 12'h184, 2'd0, 64'h5A, 64'h0, 1'b0, 4'b0100, "R10 command write");
    rd(12'h184, 2'd0, 64'h0, "R10 command reads zero");
    acc(1'b1, 12'h204, 2'd0, 64'hC3, 64'h0, 1'b0, 4'b1000, "R10 command channel 3");

    // R11 status, channel 3
    @(negedge clk);
    chan_status[3*SW +: SW] = 16'h8A00; chan_busy[3] = 1'b1;
    rd(12'h208, 2'd3, 64'h8A00, "R11 status busy");
    chan_busy[3] = 1'b0;
    rd(12'h208, 2'd3, 64'h8A01, "R11 status idle");
    wr(12'h208, 2'd3, 64'hFFFF, "R5 status write");
    rd(12'h208, 2'd3, 64'h8A01, "R5 status unchanged");

    // R12 illegal accesses
    bad(1'b0, 12'h280, 2'd1, 64'h0, "R12 channel out of range");
    bad(1'b1, 12'h290, 2'd3, 64'h1, "R12 write out-of-range channel");
    bad(1'b0, 12'h0C0, 2'd2, 64'h0, "R12 unmapped channel offset");
    bad(1'b0, 12'h010, 2'd0, 64'h0, "R12 unmapped global offset");
    bad(1'b1, 12'h080, 2'd2, 64'hFFFF, "R12 control wrong size");
    rd(12'h080, 2'd1, 64'h1231, "R12 control unchanged");
    bad(1'b1, 12'h184, 2'd1, 64'h77, "R12 command wrong size no strobe");
    bad(1'b1, 12'h114, 2'd3, 64'h5, "R12 high half 8-byte");
    rd(12'h110, 2'd3, 64'hCCCC_DDDD_AAAA_BBBB, "R12 chain unchanged");
    bad(1'b1, 12'h002, 2'd1, 64'h1, "R12 intr wrong size");
    rd(12'h002, 2'd0, 64'h0, "R12 intr unchanged");

    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 idle no response", 64'(rsp_valid), 64'h0);
    check(q_data.size() == 0, "R1 all responses seen", 64'(q_data.size()), 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule